// File: doc/BRIEF.md
# Eight-Channel Cross-Bus DMA Engine

This block copies bytes between a wide memory bus with 24-bit addresses and a narrow peripheral bus addressed by one byte. Each channel holds a control byte, a peripheral register number, a 24-bit memory address and a 16-bit byte count. Software loads these fields through a byte-wide configuration port while the engine is idle. It then writes a start mask with one bit per channel.

From that write until the last byte moves, the engine holds the processor halted. It serves the started channels one after another, lowest number first. Each byte takes a fixed slot of master clocks. A channel may move data toward either bus. The memory address can count up, count down or stay put for fills, and the peripheral register can be fixed or alternate over a pair.

Two kinds of channel never move data. One is a channel that the scanline table engine already owns. The other is a channel whose memory side and peripheral side would both land in work RAM.

Top module: `xbus_dma`

## Requirements
- R1: After reset, `halt` is low and no bus strobe (`a_rd`, `a_wr`, `b_rd`, `b_wr`) is asserted.
- R2: Pulsing `go_we` while idle starts channel i for each set bit i of `go_mask`. `halt` rises on the next clock and stays high until the final byte slot ends. A `go_we` pulse while `halt` is high has no effect.
- R3: Every byte occupies exactly CYC clocks, and its strobe is asserted in the last clock of the slot. `halt` stays high for CYC times the total number of bytes moved.
- R4: Control bit 7 picks the direction. When it is 0, data flows from the memory bus to the peripheral bus: `a_rd` and `b_wr` strobe together and `b_wdata` equals `a_rdata`. When it is 1, `b_rd` and `a_wr` strobe together and `a_wdata` equals `b_rdata`.
- R5: Control bits 4:3 set the memory address step. The value 00 adds one after each byte, 10 subtracts one, and 01 or 11 holds the address. Only the low 16 bits change, and they wrap inside the bank.
- R6: Control bits 1:0 set the peripheral register pattern. 00 uses the register for every byte. 01 alternates between the register and the register plus one, starting on the register. 10 and 11 write the same register twice per two-byte unit, so every byte goes to the register.
- R7: A channel moves as many bytes as its count field holds, and a count of 0 moves 65536 bytes.
- R8: When several channels start together, each channel finishes all of its bytes before the next higher-numbered channel begins.
- R9: A channel whose bit in `tbl_mask` is set when the start mask is written moves no data and adds no halt time.
- R10: A channel is refused if its memory address bank is 0x7E or 0x7F and its peripheral register equals WRAM_PORT (0x80). A refused channel moves no data, and the other started channels still run.
- R11: A `cfg_we` pulse writes `cfg_wdata` into the field `cfg_fld` of channel `cfg_ch`. The field codes are: 0 control, 1 peripheral register, 2 address low, 3 address middle, 4 bank, 5 count low, 6 count high. The write is ignored while `halt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel selected for the configuration write |
| cfg_fld | input | 3 | Field code for the configuration write |
| cfg_wdata | input | 8 | Configuration data byte |
| go_we | input | 1 | Start-mask write strobe |
| go_mask | input | 8 | Channels to start |
| tbl_mask | input | 8 | Channels owned by the scanline table engine |
| halt | output | 1 | Processor stall request |
| a_addr | output | 24 | Memory bus address |
| a_rd | output | 1 | Memory bus read strobe |
| a_wr | output | 1 | Memory bus write strobe |
| a_rdata | input | 8 | Memory bus read data |
| a_wdata | output | 8 | Memory bus write data |
| b_addr | output | 8 | Peripheral register number |
| b_rd | output | 1 | Peripheral bus read strobe |
| b_wr | output | 1 | Peripheral bus write strobe |
| b_rdata | input | 8 | Peripheral bus read data |
| b_wdata | output | 8 | Peripheral bus write data |

## Verification
The bench builds the engine with CYC set to 2 and keeps the other parameters at their defaults. With two clocks per byte, a full 65536-byte transfer from a zero count fits in about 131 thousand clocks. This lets the bench check the count wrap and the exact halt length together, instead of cutting the count field down to make the test shorter. A slot of two clocks still has a gap clock between strobes, so strobe spacing and strobe placement stay observable.

// File: rtl/xbus_dma.sv
module xbus_dma #(
  parameter int NCH = 8,
  parameter int CYC = 8,
  parameter logic [7:0] WRAM_PORT = 8'h80,
  parameter logic [7:0] WRAM_BANK = 8'h7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_ch,
  input  logic [2:0]       cfg_fld,
  input  logic [7:0]       cfg_wdata,
  input  logic             go_we,
  input  logic [NCH-1:0]   go_mask,
  input  logic [NCH-1:0]   tbl_mask,
  output logic             halt,
  output logic [23:0]      a_addr,
  output logic             a_rd,
  output logic             a_wr,
  input  logic [7:0]       a_rdata,
  output logic [7:0]       a_wdata,
  output logic [7:0]       b_addr,
  output logic             b_rd,
  output logic             b_wr,
  input  logic [7:0]       b_rdata,
  output logic [7:0]       b_wdata
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PHW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [7:0]     mode_q [NCH];
  logic [7:0]     breg_q [NCH];
  logic [23:0]    addr_q [NCH];
  logic [15:0]    cnt_q  [NCH];
  logic [NCH-1:0] en_q, skip;
  logic [PHW-1:0] ph_q;
  logic           tog_q;
  logic [CHW-1:0] cur;

  wire busy   = |en_q;
  wire strobe = busy && (ph_q == PHW'(CYC - 1));
  wire dir    = mode_q[cur][7];
  wire pair   = (mode_q[cur][1:0] == 2'b01);
  wire last   = (cnt_q[cur] == 16'd1);

  for (genvar g = 0; g < NCH; g++) begin : g_skip
    assign skip[g] = (addr_q[g][23:17] == WRAM_BANK[7:1]) && (breg_q[g] == WRAM_PORT);
  end

  always_comb begin
    cur = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en_q[i]) cur = CHW'(i);
  end

  assign halt    = busy;
  assign a_addr  = addr_q[cur];
  assign b_addr  = breg_q[cur] + {7'd0, pair & tog_q};
  assign a_rd    = strobe & ~dir;
  assign b_wr    = strobe & ~dir;
  assign b_rd    = strobe &  dir;
  assign a_wr    = strobe &  dir;
  assign b_wdata = a_rdata;
  assign a_wdata = b_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        breg_q[i] <= '0;
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (cfg_we && !busy) begin
      case (cfg_fld)
        3'd0: mode_q[cfg_ch]        <= cfg_wdata;
        3'd1: breg_q[cfg_ch]        <= cfg_wdata;
        3'd2: addr_q[cfg_ch][7:0]   <= cfg_wdata;
        3'd3: addr_q[cfg_ch][15:8]  <= cfg_wdata;
        3'd4: addr_q[cfg_ch][23:16] <= cfg_wdata;
        3'd5: cnt_q[cfg_ch][7:0]    <= cfg_wdata;
        3'd6: cnt_q[cfg_ch][15:8]   <= cfg_wdata;
        default: ;
      endcase
    end else if (strobe) begin
      cnt_q[cur] <= cnt_q[cur] - 16'd1;
      case (mode_q[cur][4:3])
        2'b00:   addr_q[cur][15:0] <= addr_q[cur][15:0] + 16'd1;
        2'b10:   addr_q[cur][15:0] <= addr_q[cur][15:0] - 16'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ph_q  <= '0;
      tog_q <= 1'b0;
    end else if (!busy) begin
      ph_q  <= '0;
      tog_q <= 1'b0;
      if (go_we) en_q <= go_mask & ~tbl_mask & ~skip;
    end else if (strobe) begin
      ph_q <= '0;
      if (last) begin
        en_q[cur] <= 1'b0;
        tog_q     <= 1'b0;
      end else begin
        tog_q <= ~tog_q;
      end
    end else begin
      ph_q <= ph_q + PHW'(1);
    end
  end
endmodule

// File: rtl/xbus_dma_chk.sv
module xbus_dma_chk #(
  parameter int CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic go_we,
  input logic halt,
  input logic a_rd,
  input logic a_wr,
  input logic b_rd,
  input logic b_wr
);
  wire any_rd = a_rd | b_rd;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> !(a_rd | a_wr | b_rd | b_wr));

  p_start_from_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(go_we));

  p_slot_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (CYC > 1 && any_rd) |=> !any_rd);

  p_end_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> $past(any_rd));

  p_one_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_rd | b_wr, b_rd | a_wr}));
endmodule

bind xbus_dma xbus_dma_chk #(.CYC(CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .go_we(go_we), .halt(halt),
  .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr)
);

// File: tb/test_xbus_dma.sv
module test_xbus_dma;
  localparam int CYC = 2;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, go_we = 0;
  logic [2:0] cfg_ch = 0, cfg_fld = 0;
  logic [7:0] cfg_wdata = 0, go_mask = 0, tbl_mask = 0;
  logic halt, a_rd, a_wr, b_rd, b_wr;
  logic [23:0] a_addr;
  logic [7:0] a_rdata, a_wdata, b_addr, b_rdata, b_wdata;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  assign a_rdata = mem(a_addr);
  assign b_rdata = b_addr ^ 8'hA5;

  xbus_dma #(.CYC(CYC)) i_xbus_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .go_we(go_we), .go_mask(go_mask), .tbl_mask(tbl_mask),
    .halt(halt), .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_rdata(a_rdata),
    .a_wdata(a_wdata), .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_rdata(b_rdata),
    .b_wdata(b_wdata));

  int total = 0, fails = 0, cyc = 0, hc = 0, nst = 0, nlog = 0;
  logic [23:0] la [64];
  logic [7:0]  lb [64], ld [64];
  logic        lk [64];

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (halt) hc++;
    if (a_rd | b_rd) nst++;
    if (a_wr | b_wr) begin
      if (nlog < 64) begin
        la[nlog] = a_addr; lb[nlog] = b_addr;
        ld[nlog] = b_wr ? b_wdata : a_wdata; lk[nlog] = a_wr;
      end
      nlog++;
    end
    if (cyc >= 190000) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int fld, input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_ch = 3'(ch); cfg_fld = 3'(fld); cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic setup(input int ch, input logic [7:0] md, input logic [7:0] br,
                       input logic [23:0] ad, input logic [15:0] n);
    cfg(ch, 0, md); cfg(ch, 1, br);
    cfg(ch, 2, ad[7:0]); cfg(ch, 3, ad[15:8]); cfg(ch, 4, ad[23:16]);
    cfg(ch, 5, n[7:0]); cfg(ch, 6, n[15:8]);
  endtask

  task automatic run(input logic [7:0] m);
    nlog = 0; hc = 0; nst = 0;
    @(negedge clk); go_mask = m; go_we = 1;
    @(negedge clk); go_we = 0;
    while (halt) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 halt", halt, 0);
    chk("R1 strobes", nst, 0);
  endtask

  task automatic t_inc();
    logic [23:0] ex [3] = '{24'h01FFFE, 24'h01FFFF, 24'h010000};
    setup(0, 8'h00, 8'h18, 24'h01FFFE, 16'd3);
    run(8'h01);
    chk("R7 count", nlog, 3);
    chk("R3 halt length", hc, 3 * CYC);
    for (int i = 0; i < 3; i++) begin
      chk("R5 inc wrap", la[i], ex[i]);
      chk("R6 single reg", lb[i], 8'h18);
      chk("R4 a to b data", ld[i], mem(ex[i]));
      chk("R4 direction", lk[i], 0);
    end
  endtask

  task automatic t_fill();
    setup(3, 8'h0A, 8'h22, 24'h021000, 16'd4);
    run(8'h08);
    chk("R7 count", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 fixed", la[i], 24'h021000);
      chk("R6 twice per unit", lb[i], 8'h22);
    end
  endtask

  task automatic t_dec_pair();
    setup(5, 8'h91, 8'h30, 24'h030005, 16'd4);
    run(8'h20);
    chk("R7 count", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 dec", la[i], 24'h030005 - 24'(i));
      chk("R6 pair", lb[i], 8'h30 + 8'(i % 2));
      chk("R4 b to a data", ld[i], (8'h30 + 8'(i % 2)) ^ 8'hA5);
      chk("R4 direction", lk[i], 1);
    end
  endtask

  task automatic t_order();
    setup(6, 8'h00, 8'h40, 24'h040000, 16'd2);
    setup(1, 8'h00, 8'h11, 24'h050000, 16'd1);
    run(8'h42);
    chk("R8 count", nlog, 3);
    chk("R8 first", lb[0], 8'h11);
    chk("R8 second", lb[1], 8'h40);
    chk("R8 third", lb[2], 8'h40);
    chk("R3 halt length", hc, 3 * CYC);
  endtask

  task automatic t_table();
    setup(2, 8'h00, 8'h50, 24'h060000, 16'd2);
    tbl_mask = 8'h04;
    run(8'h04);
    repeat (8) @(negedge clk);
    chk("R9 no bytes", nst, 0);
    chk("R9 no halt", hc, 0);
    tbl_mask = 8'h00;
  endtask

  task automatic t_wram();
    setup(4, 8'h00, 8'h80, 24'h7E0000, 16'd2);
    setup(7, 8'h00, 8'h60, 24'h060000, 16'd1);
    run(8'h90);
    chk("R10 only other channel", nlog, 1);
    chk("R10 other reg", lb[0], 8'h60);
    chk("R10 halt length", hc, CYC);
  endtask

  task automatic t_busy();
    setup(0, 8'h00, 8'h18, 24'h010000, 16'd6);
    setup(1, 8'h00, 8'h11, 24'h050000, 16'd1);
    nlog = 0; hc = 0; nst = 0;
    @(negedge clk); go_mask = 8'h01; go_we = 1;
    @(negedge clk); go_we = 0;
    @(negedge clk); cfg_we = 1; cfg_ch = 0; cfg_fld = 1; cfg_wdata = 8'h77;
    go_mask = 8'h02; go_we = 1;
    @(negedge clk); cfg_we = 0; go_we = 0;
    while (halt) @(negedge clk);
    @(negedge clk);
    chk("R2 late start ignored", nlog, 6);
    chk("R2 halt length", hc, 6 * CYC);
    for (int i = 0; i < 6; i++) chk("R11 busy cfg ignored", lb[i], 8'h18);
  endtask

  task automatic t_big();
    setup(0, 8'h08, 8'h19, 24'h012345, 16'd0);
    run(8'h01);
    chk("R7 zero count", nlog, 65536);
    chk("R3 long halt", hc, 65536 * CYC);
    chk("R7 fill data", ld[63], mem(24'h012345));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_inc();
    t_fill();
    t_dec_pair();
    t_order();
    t_table();
    t_wram();
    t_busy();
    t_big();
    summary();
  end
endmodule